// File: doc/BRIEF.md
# Sync-to-Video Delay Aligner

This block moves a luma stream, and separately the blue-difference stream, forward or backward in time against a sync/blanking strobe. The shift is a small signed number of pixel-clock cycles, from three cycles early to three cycles late. It sits just before the output converters, so that the picture can be lined up with the sync edges. It can also correct a skew between the two colour-difference channels.

The sync strobe and the red-difference stream pass through a fixed three-stage pipeline. The luma and blue-difference streams pass through six-stage pipelines. The output for each of those two streams is taken from a tap chosen by its 3-bit code, so the total latency seen at the sync output never changes.

A new code is picked up only on a rising edge of the sync strobe. A line is therefore never split between two alignments.

Top module: `sync_video_aligner`

## Requirements
- R1: While reset is held and inputs are zero, and after reset is released, every output is zero until non-zero input has travelled through the pipeline.
- R2: `sync_out` equals `sync_in` from exactly 3 cycles earlier, and `cr_out` equals `cr_in` from exactly 3 cycles earlier, whatever the codes are.
- R3: Luma delay codes are 000, 001, 010 and 011. They give `y_out` equal to `y_in` from 3, 4, 5 and 6 cycles earlier, so the video is 0 to 3 cycles late against sync.
- R4: Luma advance codes are 111, 110 and 101. They give `y_out` equal to `y_in` from 2, 1 and 0 cycles earlier, so the video is 1, 2 and 3 cycles early against sync.
- R5: The reserved code 100 behaves exactly like 000 (no offset).
- R6: `cb_code` uses the same code mapping for `cb_out` as `y_code` uses for luma. The offset is measured against `cr_out`, which always has a latency of 3.
- R7: A code becomes active at the clock edge where `sync_in` is 1 and was 0 at the previous edge. A code change at any other time has no effect on the outputs until that edge.
- R8: The luma and blue-difference codes act independently: one setting never alters the other stream's alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Composite sync/blanking strobe; its rising edge marks a line start |
| y_in | input | 10 | Luma sample |
| cb_in | input | 10 | Blue-difference sample |
| cr_in | input | 10 | Red-difference sample |
| y_code | input | 3 | Luma offset code against sync |
| cb_code | input | 3 | Blue-difference offset code against red-difference |
| sync_out | output | 1 | Sync strobe, 3 cycles late |
| y_out | output | 10 | Realigned luma |
| cb_out | output | 10 | Realigned blue-difference |
| cr_out | output | 10 | Red-difference, 3 cycles late |

## Verification
Every pair of luma and blue-difference codes, 64 in all, is swept. Each data stream carries a different counting ramp, so a tap that is one stage off shows up as a wrong value rather than a repeated one. The codes are changed in the middle of a line and held across the sync rising edge. This separates a design that applies a code at once from one that waits for the line start. Giving the two fields different codes in the same run also catches any cross-coupling between the luma and chroma taps.

// File: rtl/sync_video_aligner.sv
module sync_video_aligner #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] cb_in,
  input  logic [W-1:0] cr_in,
  input  logic [2:0]   y_code,
  input  logic [2:0]   cb_code,
  output logic         sync_out,
  output logic [W-1:0] y_out,
  output logic [W-1:0] cb_out,
  output logic [W-1:0] cr_out
);
  localparam int M = 3;
  localparam int D = 2 * M;

  logic         sync_q;
  logic [2:0]   act_y, act_cb;
  logic [M-1:0] sync_pipe;
  logic [W-1:0] y_tap  [0:D];
  logic [W-1:0] cb_tap [0:D];
  logic [W-1:0] cr_tap [0:M];

  function automatic logic [2:0] tap_of(input logic [2:0] c);
    if (!c[2])               return 3'(M) + {1'b0, c[1:0]};
    else if (c[1:0] == 2'd0) return 3'(M);
    else                     return 3'(M) - (3'd4 - {1'b0, c[1:0]});
  endfunction

  wire line_start = sync_in && !sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      act_y  <= 3'd0;
      act_cb <= 3'd0;
    end else begin
      sync_q <= sync_in;
      if (line_start) begin
        act_y  <= y_code;
        act_cb <= cb_code;
      end
    end
  end

  assign y_tap[0]  = y_in;
  assign cb_tap[0] = cb_in;
  assign cr_tap[0] = cr_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_pipe <= '0;
      for (int i = 1; i <= D; i++) begin
        y_tap[i]  <= '0;
        cb_tap[i] <= '0;
      end
      for (int i = 1; i <= M; i++) cr_tap[i] <= '0;
    end else begin
      sync_pipe <= {sync_pipe[M-2:0], sync_in};
      for (int i = 1; i <= D; i++) begin
        y_tap[i]  <= y_tap[i-1];
        cb_tap[i] <= cb_tap[i-1];
      end
      for (int i = 1; i <= M; i++) cr_tap[i] <= cr_tap[i-1];
    end
  end

  assign sync_out = sync_pipe[M-1];
  assign cr_out   = cr_tap[M];
  assign y_out    = y_tap[tap_of(act_y)];
  assign cb_out   = cb_tap[tap_of(act_cb)];
endmodule

module sync_video_aligner_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sync_in,
  input logic         sync_q,
  input logic [W-1:0] y_in,
  input logic [W-1:0] cr_in,
  input logic [2:0]   act_y,
  input logic         sync_out,
  input logic [W-1:0] y_out,
  input logic [W-1:0] cr_out
);
  logic [3:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
  end

  a_r2_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd3) |-> sync_out == $past(sync_in, 3));
  a_r2_cr_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd3) |-> cr_out == $past(cr_in, 3));
  a_r3_late3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd6 && act_y == 3'b011) |-> y_out == $past(y_in, 6));
  a_r4_early3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_y == 3'b101) |-> y_out == y_in);
  a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'd3 && act_y == 3'b100) |-> y_out == $past(y_in, 3));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_in && !sync_q) |=> $stable(act_y));
endmodule

bind sync_video_aligner sync_video_aligner_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_q(sync_q),
  .y_in(y_in), .cr_in(cr_in), .act_y(act_y), .sync_out(sync_out),
  .y_out(y_out), .cr_out(cr_out));

// File: tb/sync_video_aligner_tb.sv
module sync_video_aligner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic clk = 0, rst_n = 0, sync_in = 0;
  logic [W-1:0] y_in = 0, cb_in = 0, cr_in = 0;
  logic [2:0] y_code = 0, cb_code = 0;
  logic sync_out;
  logic [W-1:0] y_out, cb_out, cr_out;

  sync_video_aligner #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .y_in(y_in), .cb_in(cb_in),
    .cr_in(cr_in), .y_code(y_code), .cb_code(cb_code), .sync_out(sync_out),
    .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [W-1:0] yh [0:6], cbh [0:6], crh [0:6];
  logic sh [0:6];
  logic [2:0] m_act_y = 0, m_act_cb = 0;
  logic m_sync_q = 0;
  logic done = 0;

  function automatic int lag_of(input logic [2:0] c);
    if (!c[2]) return 3 + int'(c[1:0]);
    if (c[1:0] == 2'd0) return 3;
    return 3 - (4 - int'(c[1:0]));
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    if (c == 3'b100) return "R5";
    return c[2] ? "R4" : "R3";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic push(input logic s, input logic [W-1:0] y, cb, cr);
    for (int i = 6; i > 0; i--) begin
      yh[i] = yh[i-1]; cbh[i] = cbh[i-1]; crh[i] = crh[i-1]; sh[i] = sh[i-1];
    end
    yh[0] = y; cbh[0] = cb; crh[0] = cr; sh[0] = s;
    sync_in = s; y_in = y; cb_in = cb; cr_in = cr;
  endtask

  task automatic cycle(input logic s, input logic [W-1:0] y, cb, cr);
    push(s, y, cb, cr);
    @(negedge clk);
    chk("R2 sync", int'(sync_out), int'(sh[3]));
    chk("R2 cr", int'(cr_out), int'(crh[3]));
    chk(tag_of(m_act_y), int'(y_out), int'(yh[lag_of(m_act_y)]));
    chk({"R6 ", tag_of(m_act_cb)}, int'(cb_out), int'(cbh[lag_of(m_act_cb)]));
    if (m_act_y != y_code || m_act_cb != cb_code) begin
      chk("R7 y", int'(y_out), int'(yh[lag_of(m_act_y)]));
      chk("R7 cb", int'(cb_out), int'(cbh[lag_of(m_act_cb)]));
    end
    @(posedge clk);
    if (s && !m_sync_q) begin m_act_y = y_code; m_act_cb = cb_code; end
    m_sync_q = s;
    #1;
  endtask

  initial begin
    for (int i = 0; i < 7; i++) begin yh[i] = 0; cbh[i] = 0; crh[i] = 0; sh[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sync", int'(sync_out), 0);
    chk("R1 y", int'(y_out), 0);
    chk("R1 cb", int'(cb_out), 0);
    chk("R1 cr", int'(cr_out), 0);
    rst_n = 1;
    begin
      int t = 0;
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          for (int k = 0; k < 20; k++) begin
            if (k == 10) begin y_code = 3'(a); cb_code = 3'((a + b) % 8); end
            cycle(k < 4 && k > 0, W'(t * 3 + 1), W'(t * 5 + 7), W'(t * 7 + 2));
            t++;
          end
          for (int k = 0; k < 20; k++) begin
            cycle(k < 4 && k > 0, W'(t * 3 + 1), W'(t * 5 + 7), W'(t * 7 + 2));
            t++;
          end
          // R8: codes differ per stream across the sweep; both checks ran above
        end
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule